// File: doc/BRIEF.md
# Truncating Float-to-Signed-Integer Converter

This block takes one IEEE-754 binary floating-point operand and produces a signed two's-complement integer. The fractional part is always dropped, so the result moves toward zero, and the global rounding mode has no effect. A 2-bit format code selects the source precision, which can be half, single or double. A 1-bit size select chooses a 32-bit or a 64-bit result. One datapath handles all six pairs of source precision and result width.

Special operands are resolved inside the block. NaN inputs give zero. Infinities and magnitudes that do not fit the chosen width saturate to the extreme of that width. Zeros and subnormals give zero.

There are two exception classes, invalid and inexact, and each has its own trap-enable input. When an exception's trap is disabled, it sets its status flag. When the trap is enabled, the exception raises a synchronous trap request and its flag stays clear. The flags report the conversion just completed; accumulating them into sticky bits is left to the surrounding logic.

Result, flags, trap request and an undefined-encoding indication are all registered. They appear together with a valid strobe one clock after the input strobe.

Top module: `fp_trunc_int`

## Requirements
- R1: A positive finite value in range converts to the integer part of its magnitude, with the fraction discarded. For example, the double 4412.67 converts to 4412.
- R2: A negative finite value in range converts to the two's complement of its truncated magnitude. For example, -2.7 converts to -2, which is 64'hFFFF_FFFF_FFFF_FFFE in 64-bit mode.
- R3: `fmt` selects the source precision:
  - 2'b11 is half precision, taken from `src[15:0]`.
  - 2'b00 is single precision, taken from `src[31:0]`.
  - 2'b01 is double precision, taken from `src[63:0]`.
  - Source bits above the selected width have no effect on any output.
- R4: `wide`=1 gives a 64-bit result. `wide`=0 gives a 32-bit result in `result[31:0]`, and `result[63:32]` is then zero.
- R5: A NaN of any format gives result 0 and signals invalid, never inexact.
- R6: An infinity, or a value whose truncated integer lies outside the signed range of the selected width, saturates and signals invalid, never inexact. Positive values saturate to 2^(N-1)-1 and negative values to -2^(N-1). The value -2^(N-1) itself converts exactly.
- R7: Inexact is signalled when nonzero fraction bits are discarded from a non-saturated, non-NaN conversion. Zeros of either sign and subnormals give 0. A nonzero subnormal also signals inexact.
- R8: For each exception class, the trap-enable input decides the response:
  - Enable 0: the exception sets its flag and does not raise `trap_req`.
  - Enable 1: the exception raises `trap_req` and leaves its flag clear.
- R9: The reserved code `fmt`=2'b10 gives result 0, no flags and no trap request, and raises `undef_op`.
- R10: `out_valid` is high exactly one clock after each cycle in which `in_valid` is high, and low otherwise. Flags, trap request and `undef_op` are low whenever `out_valid` is low. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| src | input | 64 | Floating-point operand, right-aligned |
| fmt | input | 2 | Source precision code |
| wide | input | 1 | Result size: 0 = 32 bits, 1 = 64 bits |
| trap_inv_en | input | 1 | Route invalid to a trap instead of a flag |
| trap_inx_en | input | 1 | Route inexact to a trap instead of a flag |
| result | output | 64 | Converted integer |
| out_valid | output | 1 | Result strobe |
| flag_invalid | output | 1 | Invalid status for this conversion |
| flag_inexact | output | 1 | Inexact status for this conversion |
| trap_req | output | 1 | Synchronous trap request |
| undef_op | output | 1 | Reserved format code seen |

## Verification
The block has no parameters, so the bench uses its single fixed configuration. Half precision is small enough to sweep all 65536 encodings. That sweep covers every subnormal, NaN payload and exponent. Upper source bits and trap enables are scrambled per vector, and the result size alternates. Single and double precision are swept over every exponent in a band that crosses both result-width limits, with edge fractions in each. Directed vectors cover the exact -2^(N-1) and 2^(N-1) boundaries.

// File: rtl/fp_trunc_int.sv
module fp_trunc_int (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] src,
  input  logic [1:0]  fmt,
  input  logic        wide,
  input  logic        trap_inv_en,
  input  logic        trap_inx_en,
  output logic [63:0] result,
  output logic        out_valid,
  output logic        flag_invalid,
  output logic        flag_inexact,
  output logic        trap_req,
  output logic        undef_op
);

  logic        sgn;
  logic [10:0] bexp;
  logic [51:0] frac;
  logic [10:0] bias;
  logic [10:0] emax;

  always_comb begin
    sgn  = 1'b0;
    bexp = '0;
    frac = '0;
    bias = 11'd1023;
    emax = 11'h7ff;
    case (fmt)
      2'b11: begin
        sgn  = src[15];
        bexp = {6'd0, src[14:10]};
        frac = {src[9:0], 42'd0};
        bias = 11'd15;
        emax = 11'd31;
      end
      2'b00: begin
        sgn  = src[31];
        bexp = {3'd0, src[30:23]};
        frac = {src[22:0], 29'd0};
        bias = 11'd127;
        emax = 11'd255;
      end
      2'b01: begin
        sgn  = src[63];
        bexp = src[62:52];
        frac = src[51:0];
      end
      default: ;
    endcase
  end

  wire reserved = (fmt == 2'b10);
  wire zexp     = (bexp == 11'd0);
  wire topexp   = (bexp == emax);
  wire is_nan   = topexp && (frac != 52'd0);
  wire is_inf   = topexp && (frac == 52'd0);

  wire signed [12:0] uexp = $signed({2'b00, bexp}) - $signed({2'b00, bias});
  wire below_one = zexp || (uexp < 13'sd0);
  wire too_big   = !zexp && !topexp && (uexp > 13'sd63);

  wire [115:0] aligned   = {63'd0, 1'b1, frac} << uexp[5:0];
  wire [63:0]  mag       = below_one ? 64'd0 : aligned[115:52];
  wire         frac_lost = below_one ? (!zexp || frac != 52'd0) : (aligned[51:0] != 52'd0);

  wire fits64   = !mag[63] || (sgn && mag[62:0] == 63'd0);
  wire fits32   = (mag[63:32] == 32'd0) && (!mag[31] || (sgn && mag[30:0] == 31'd0));
  wire overflow = is_inf || too_big || (!topexp && !(wide ? fits64 : fits32));

  wire [63:0] sat = wide ? (sgn ? 64'h8000_0000_0000_0000 : 64'h7fff_ffff_ffff_ffff)
                         : (sgn ? 64'h0000_0000_8000_0000 : 64'h0000_0000_7fff_ffff);
  wire [63:0] smag   = sgn ? (64'd0 - mag) : mag;
  wire [63:0] sized  = wide ? smag : {32'd0, smag[31:0]};
  wire [63:0] nxt    = (reserved || is_nan) ? 64'd0 : (overflow ? sat : sized);

  wire exc_inv = !reserved && (is_nan || overflow);
  wire exc_inx = !reserved && !is_nan && !overflow && frac_lost;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result       <= '0;
      out_valid    <= 1'b0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
      trap_req     <= 1'b0;
      undef_op     <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      flag_invalid <= in_valid && exc_inv && !trap_inv_en;
      flag_inexact <= in_valid && exc_inx && !trap_inx_en;
      trap_req     <= in_valid && ((exc_inv && trap_inv_en) || (exc_inx && trap_inx_en));
      undef_op     <= in_valid && reserved;
      if (in_valid) result <= nxt;
    end
  end

endmodule

// File: rtl/fp_trunc_int_chk.sv
module fp_trunc_int_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  fmt,
  input logic        wide,
  input logic        trap_inv_en,
  input logic        trap_inx_en,
  input logic [63:0] result,
  input logic        out_valid,
  input logic        flag_invalid,
  input logic        flag_inexact,
  input logic        trap_req,
  input logic        undef_op
);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !flag_invalid && !flag_inexact && !trap_req && !undef_op);

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !wide |=> result[63:32] == 32'd0);

  assert_reserved_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && fmt == 2'b10 |=> undef_op && result == 64'd0 && !flag_invalid && !flag_inexact && !trap_req);

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(flag_invalid && flag_inexact));

  assert_inv_trapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && trap_inv_en |=> !flag_invalid);

  assert_inx_trapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && trap_inx_en |=> !flag_inexact);

  assert_no_trap_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !trap_inv_en && !trap_inx_en |=> !trap_req);

endmodule

bind fp_trunc_int fp_trunc_int_chk u_chk (.*);

// File: tb/fp_trunc_int_test.sv
module fp_trunc_int_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] src;
  logic [1:0]  fmt;
  logic        wide;
  logic        trap_inv_en;
  logic        trap_inx_en;
  logic [63:0] result;
  logic        out_valid;
  logic        flag_invalid;
  logic        flag_inexact;
  logic        trap_req;
  logic        undef_op;

  always #10 clk = ~clk;

  fp_trunc_int uut (.*);

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL R10 watchdog: actual cycles=%0d expected <= 200000", cycles);
      summary();
      $finish;
    end
  end

  function automatic void model(input logic [63:0] s, input logic [1:0] f, input logic w,
                                output logic [63:0] r, output logic inv, output logic inx);
    real v, tr, lim;
    int e;
    longint fr;
    bit sg, nan, inf;
    longint q;
    sg = 0; nan = 0; inf = 0; v = 0.0;
    case (f)
      2'b11: begin
        sg = s[15]; e = int'(s[14:10]); fr = longint'(s[9:0]);
        nan = (e == 31) && (fr != 0); inf = (e == 31) && (fr == 0);
        v = (e == 0) ? (fr / 1024.0) * 2.0 ** (-14) : (1.0 + fr / 1024.0) * 2.0 ** (e - 15);
        if (sg) v = -v;
      end
      2'b00: begin
        sg = s[31]; e = int'(s[30:23]); fr = longint'(s[22:0]);
        nan = (e == 255) && (fr != 0); inf = (e == 255) && (fr == 0);
        v = (e == 0) ? (fr / 8388608.0) * 2.0 ** (-126) : (1.0 + fr / 8388608.0) * 2.0 ** (e - 127);
        if (sg) v = -v;
      end
      2'b01: begin
        sg = s[63]; e = int'(s[62:52]);
        nan = (e == 2047) && (s[51:0] != 0); inf = (e == 2047) && (s[51:0] == 0);
        if (!nan && !inf) v = $bitstoreal(s);
      end
      default: ;
    endcase
    r = 64'd0; inv = 0; inx = 0;
    if (f == 2'b10) begin
    end else if (nan) begin
      inv = 1;
    end else begin
      tr  = (v < 0.0) ? -$floor(-v) : $floor(v);
      lim = w ? 9223372036854775808.0 : 2147483648.0;
      if (inf || tr >= lim || tr < -lim) begin
        inv = 1;
        r = w ? (sg ? 64'h8000_0000_0000_0000 : 64'h7fff_ffff_ffff_ffff)
              : (sg ? 64'h0000_0000_8000_0000 : 64'h0000_0000_7fff_ffff);
      end else begin
        inx = (tr != v);
        q = longint'(tr);
        r = w ? q : {32'd0, q[31:0]};
      end
    end
  endfunction

  task automatic apply(input logic [63:0] s, input logic [1:0] f, input logic w,
                       input logic ti, input logic tx, input string tag);
    logic [63:0] er;
    logic ei, ex, et, eu;
    model(s, f, w, er, ei, ex);
    et = (ei && ti) || (ex && tx);
    eu = (f == 2'b10);
    src = s; fmt = f; wide = w; trap_inv_en = ti; trap_inx_en = tx; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (result !== er || out_valid !== 1'b1 || flag_invalid !== (ei && !ti) ||
        flag_inexact !== (ex && !tx) || trap_req !== et || undef_op !== eu) begin
      errors++;
      $display("FAIL %s src=%h fmt=%b wide=%b ti=%b tx=%b: actual res=%h vld=%b inv=%b inx=%b trap=%b und=%b expected res=%h vld=1 inv=%b inx=%b trap=%b und=%b",
               tag, s, f, w, ti, tx, result, out_valid, flag_invalid, flag_inexact, trap_req, undef_op,
               er, ei && !ti, ex && !tx, et, eu);
    end
  endtask

  task automatic idle_check(input string tag);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || flag_invalid !== 1'b0 || flag_inexact !== 1'b0 ||
        trap_req !== 1'b0 || undef_op !== 1'b0) begin
      errors++;
      $display("FAIL %s idle: actual vld=%b inv=%b inx=%b trap=%b und=%b expected all 0",
               tag, out_valid, flag_invalid, flag_inexact, trap_req, undef_op);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src = '0; fmt = 2'b01; wide = 1'b0;
    trap_inv_en = 1'b0; trap_inx_en = 1'b0;
    repeat (3) @(negedge clk);
    vectors++;
    if (result !== 64'd0 || out_valid !== 1'b0 || flag_invalid !== 1'b0 ||
        flag_inexact !== 1'b0 || trap_req !== 1'b0 || undef_op !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: actual res=%h vld=%b expected res=0 vld=0", result, out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: positive truncation
    apply($realtobits(4412.67), 2'b01, 1'b0, 1'b0, 1'b0, "R1");
    apply($realtobits(4412.67), 2'b01, 1'b1, 1'b0, 1'b0, "R1");
    // R2 and R4: negative truncation in both widths
    apply($realtobits(-2.7), 2'b01, 1'b1, 1'b0, 1'b0, "R2");
    apply($realtobits(-2.7), 2'b01, 1'b0, 1'b0, 1'b0, "R4");
    // R5: NaN in every format
    apply(64'h0000_0000_0000_7e01, 2'b11, 1'b0, 1'b0, 1'b0, "R5");
    apply(64'h0000_0000_ffc0_0000, 2'b00, 1'b1, 1'b0, 1'b0, "R5");
    apply(64'h7ff8_0000_0000_0001, 2'b01, 1'b1, 1'b0, 1'b0, "R5");
    // R6: infinities and range edges
    apply(64'hfff0_0000_0000_0000, 2'b01, 1'b1, 1'b0, 1'b0, "R6");
    apply($realtobits(2147483648.0), 2'b01, 1'b0, 1'b0, 1'b0, "R6");
    apply($realtobits(-2147483648.0), 2'b01, 1'b0, 1'b0, 1'b0, "R6");
    apply($realtobits(-2147483648.5), 2'b01, 1'b0, 1'b0, 1'b0, "R6");
    apply($realtobits(2147483647.9), 2'b01, 1'b0, 1'b0, 1'b0, "R6");
    apply($realtobits(9223372036854775808.0), 2'b01, 1'b1, 1'b0, 1'b0, "R6");
    apply($realtobits(-9223372036854775808.0), 2'b01, 1'b1, 1'b0, 1'b0, "R6");
    apply($realtobits(1.0e30), 2'b01, 1'b1, 1'b0, 1'b0, "R6");
    // R7: zeros and subnormals
    apply(64'h8000_0000_0000_0000, 2'b01, 1'b1, 1'b0, 1'b0, "R7");
    apply(64'h0000_0000_0000_0001, 2'b01, 1'b0, 1'b0, 1'b0, "R7");
    // R8: traps instead of flags
    apply($realtobits(0.5), 2'b01, 1'b0, 1'b0, 1'b1, "R8");
    apply(64'h7ff0_0000_0000_0000, 2'b01, 1'b0, 1'b1, 1'b0, "R8");
    apply(64'h7ff0_0000_0000_0000, 2'b01, 1'b0, 1'b0, 1'b1, "R8");
    // R9: reserved code
    apply($realtobits(3.5), 2'b10, 1'b1, 1'b1, 1'b1, "R9");
    apply(64'h7ff8_0000_0000_0000, 2'b10, 1'b0, 1'b0, 1'b0, "R9");
    // R10: gap in strobe
    idle_check("R10");
    apply($realtobits(7.0), 2'b01, 1'b0, 1'b0, 1'b0, "R10");
    idle_check("R10");

    // R3: every half encoding, scrambled upper bits
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] h;
      logic [31:0] m;
      h = 16'(i);
      m = i * 32'd40503;
      apply({m[15:0], ~h, h ^ 16'h5a5a, h}, 2'b11, h[0] ^ h[7], h[3] & h[11], h[5] & h[9], "R3");
    end

    // R3/R7: single precision over all exponents
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 8; k++) begin
        logic [22:0] fr;
        logic [31:0] mix;
        mix = k * 32'h0012_3457 ^ (e << 5);
        fr = (k == 0) ? 23'd0 : (k == 1) ? 23'd1 : (k == 2) ? 23'h7fffff : mix[22:0];
        for (int w = 0; w < 2; w++)
          apply({mix, k[0] ^ e[0], 8'(e), fr}, 2'b00, w[0], 1'b0, 1'b0, "R3");
      end
    end

    // R3/R6: double precision over a band crossing both limits
    for (int e = 1000; e < 1100; e++) begin
      for (int k = 0; k < 4; k++) begin
        logic [51:0] fr;
        fr = (k == 0) ? 52'd0 : (k == 1) ? 52'd1 : (k == 2) ? {52{1'b1}} : 52'h8_0000_0000_0000;
        for (int sg = 0; sg < 2; sg++)
          for (int w = 0; w < 2; w++)
            apply({sg[0], 11'(e), fr}, 2'b01, w[0], 1'b0, 1'b0, "R6");
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    summary();
    $finish;
  end
endmodule